// File: doc/BRIEF.md
# Eight-Entry Addressable Bit Latch with Demultiplex Mode

This block keeps eight single-bit entries and shows all of them in parallel on an eight-bit output. A binary select picks one entry, and a single data bit can be written into that entry. Two active-low controls, a clear and an enable, choose between four behaviours:
- a selective write, where only the picked entry changes;
- a hold, where nothing changes;
- a one-hot demultiplex, where the data bit is routed to the picked output and all other outputs are driven low;
- a clear, where all outputs go low.

The storage is a register clocked by the system clock. Writes in the selective write mode land on the rising edge. When the clear input is low, the outputs are overridden at once, without waiting for an edge, so that the clear still acts asynchronously at the ports.

While the clear input is low, each rising edge also loads the register with what the outputs show. When the clear input returns high, the register therefore holds either all zeros (after a clear) or a one-hot pattern carrying the last data bit (after a demultiplex). Typical uses are serial-to-parallel collection of control bits and active-high one-of-eight decoding.

Top module: `addr_latch8`

## Requirements
- R1: With `clr_n`=1 and `en_n`=0, the entry picked by `sel` takes the value of `din` on the rising clock edge. The new value appears on `q_out` after that edge and not before it.
- R2: During a write (`clr_n`=1, `en_n`=0), every entry other than the picked one keeps its value.
- R3: With `clr_n`=1 and `en_n`=1, no entry changes on any edge, whatever `sel` and `din` do.
- R4: With `clr_n`=0 and `en_n`=0, `q_out[sel]` equals `din` and every other output bit is 0. This holds without waiting for a clock edge.
- R5: With `clr_n`=0 and `en_n`=1, all eight outputs are 0 as soon as the inputs settle, without a clock edge. `sel` and `din` have no effect.
- R6: `sel` is an unsigned binary number with bit 2 as the MSB. Code k addresses entry k, shown on `q_out[k]`, so code 0 selects `q_out[0]` and code 7 selects `q_out[7]`.
- R7: After a clock edge in demultiplex mode, the stored pattern is all zeros except the entry picked at that edge, which holds the `din` sampled there. This is visible on `q_out` once `clr_n` returns high. A low `clr_n` therefore wins over a write request.
- R8: After a clock edge in clear mode, all stored entries are 0. This is visible on `q_out` once `clr_n` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; register updates on the rising edge |
| clr_n | input | 1 | Active-low clear; selects clear or demultiplex mode when low |
| en_n | input | 1 | Active-low enable; high means no data is written |
| sel | input | 3 | Binary entry select, bit 2 most significant |
| din | input | 1 | Data bit for the selected entry |
| q_out | output | 8 | Parallel view of the eight entries, bit k is entry k |

## Verification
The hardest situation to reach is the register content left behind by a demultiplex or clear phase. While `clr_n` is low, the outputs are overridden, so that stored pattern cannot be seen directly. Each demultiplex or clear step is therefore followed immediately by a hold step, with a different select and the opposite data bit, which exposes the captured pattern. Before every demultiplex step, the bench first fills all entries with ones, so that any entry the phase failed to zero shows up at the output.

// File: rtl/al_pkg.sv
package al_pkg;

    // Operating modes chosen by the active-low clear/enable pair.
    typedef enum logic [1:0] {
        MODE_WRITE = 2'd0,
        MODE_HOLD  = 2'd1,
        MODE_DEMUX = 2'd2,
        MODE_CLEAR = 2'd3
    } al_mode_e;

endpackage

// File: rtl/al_mode_dec.sv
module al_mode_dec
    import al_pkg::*;
(
    input  logic     clr_n,
    input  logic     en_n,
    output al_mode_e mode
);

    always_comb begin
        unique case ({clr_n, en_n})
            2'b10:   mode = MODE_WRITE;
            2'b11:   mode = MODE_HOLD;
            2'b00:   mode = MODE_DEMUX;
            default: mode = MODE_CLEAR;
        endcase
    end

endmodule

// File: rtl/al_sel_dec.sv
module al_sel_dec #(
    parameter int ENTRIES = 8,
    parameter int SEL_W   = $clog2(ENTRIES)
) (
    input  logic [SEL_W-1:0]   sel,
    output logic [ENTRIES-1:0] hit
);

    for (genvar i = 0; i < ENTRIES; i++) begin : g_hit
        assign hit[i] = (sel == SEL_W'(i));
    end

endmodule

// File: rtl/al_store.sv
module al_store
    import al_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic               clk,
    input  al_mode_e           mode,
    input  logic [ENTRIES-1:0] hit,
    input  logic               din,
    output logic [ENTRIES-1:0] bits_q
);

    typedef struct packed {
        logic [ENTRIES-1:0] bits;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (mode)
            MODE_WRITE: begin
                for (int i = 0; i < ENTRIES; i++) begin
                    if (hit[i]) st_d.bits[i] = din;
                end
            end
            MODE_HOLD:  st_d = st_q;
            MODE_DEMUX: st_d.bits = hit & {ENTRIES{din}};
            default:    st_d.bits = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign bits_q = st_q.bits;

endmodule

// File: rtl/al_out_mux.sv
module al_out_mux
    import al_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  al_mode_e           mode,
    input  logic [ENTRIES-1:0] hit,
    input  logic               din,
    input  logic [ENTRIES-1:0] bits_q,
    output logic [ENTRIES-1:0] q
);

    // Clear-side modes override the register without a clock edge.
    always_comb begin
        unique case (mode)
            MODE_DEMUX: q = hit & {ENTRIES{din}};
            MODE_CLEAR: q = '0;
            default:    q = bits_q;
        endcase
    end

endmodule

// File: rtl/addr_latch8.sv
module addr_latch8
    import al_pkg::*;
#(
    parameter  int ENTRIES = 8,
    localparam int SEL_W   = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               clr_n,
    input  logic               en_n,
    input  logic [SEL_W-1:0]   sel,
    input  logic               din,
    output logic [ENTRIES-1:0] q_out
);

    al_mode_e           mode;
    logic [ENTRIES-1:0] hit;
    logic [ENTRIES-1:0] bits_q;

    al_mode_dec u_mode (
        .clr_n (clr_n),
        .en_n  (en_n),
        .mode  (mode)
    );

    al_sel_dec #(.ENTRIES(ENTRIES), .SEL_W(SEL_W)) u_sel (
        .sel (sel),
        .hit (hit)
    );

    al_store #(.ENTRIES(ENTRIES)) u_store (
        .clk    (clk),
        .mode   (mode),
        .hit    (hit),
        .din    (din),
        .bits_q (bits_q)
    );

    al_out_mux #(.ENTRIES(ENTRIES)) u_out (
        .mode   (mode),
        .hit    (hit),
        .din    (din),
        .bits_q (bits_q),
        .q      (q_out)
    );

endmodule

// File: rtl/addr_latch8_chk.sv
module addr_latch8_chk #(
    parameter int ENTRIES = 8,
    parameter int SEL_W   = $clog2(ENTRIES)
) (
    input logic               clk,
    input logic               clr_n,
    input logic               en_n,
    input logic [SEL_W-1:0]   sel,
    input logic               din,
    input logic [ENTRIES-1:0] q_out
);

    // Register contents are defined only after one edge with clear low.
    logic armed_q;
    initial armed_q = 1'b0;
    always @(posedge clk) begin
        if (!clr_n) armed_q <= 1'b1;
    end

    p_write_bit_r1: assert property (@(posedge clk) disable iff (!armed_q)
        (clr_n && !en_n) |=> (!clr_n || q_out[$past(sel)] == $past(din)));

    p_write_others_r2: assert property (@(posedge clk) disable iff (!armed_q)
        (clr_n && !en_n) |=> (!clr_n ||
            ((q_out ^ $past(q_out)) & ~(ENTRIES'(1) << $past(sel))) == '0));

    p_hold_r3: assert property (@(posedge clk) disable iff (!armed_q)
        (clr_n && en_n) |=> (!clr_n || $stable(q_out)));

    p_demux_r4: assert property (@(posedge clk)
        (!clr_n && !en_n) |-> (q_out[sel] == din && $countones(q_out) <= 1));

    p_clear_r5: assert property (@(posedge clk)
        (!clr_n && en_n) |-> (q_out == '0));

    p_demux_store_r7: assert property (@(posedge clk) disable iff (!armed_q)
        (!clr_n && !en_n) |=> (!clr_n ||
            q_out == (ENTRIES'($past(din)) << $past(sel))));

    p_clear_store_r8: assert property (@(posedge clk) disable iff (!armed_q)
        (!clr_n && en_n) |=> (!clr_n || q_out == '0));

endmodule

bind addr_latch8 addr_latch8_chk #(.ENTRIES(ENTRIES), .SEL_W(SEL_W)) u_chk (
    .clk   (clk),
    .clr_n (clr_n),
    .en_n  (en_n),
    .sel   (sel),
    .din   (din),
    .q_out (q_out)
);

// File: tb/test_addr_latch8.sv
module test_addr_latch8;

    logic       clk = 1'b0;
    logic       clr_n = 1'b0;
    logic       en_n = 1'b1;
    logic [2:0] sel = 3'd0;
    logic       din = 1'b0;
    logic [7:0] q_out;

    int   n_checks = 0;
    int   n_errs   = 0;
    bit   done     = 1'b0;
    logic [7:0] ref_q = 8'h00;

    always #4 clk = ~clk;   // 125 MHz

    addr_latch8 i_addr_latch8 (
        .clk   (clk),
        .clr_n (clr_n),
        .en_n  (en_n),
        .sel   (sel),
        .din   (din),
        .q_out (q_out)
    );

    // Output predicted from the requirements for the current inputs.
    function automatic logic [7:0] exp_now();
        if (!clr_n && en_n)  return 8'h00;                    // R5
        if (!clr_n && !en_n) return {7'b0, din} << sel;       // R4 R6
        return ref_q;
    endfunction

    task automatic check(input logic [7:0] expv, input string req);
        n_checks++;
        if (q_out !== expv) begin
            n_errs++;
            $display("FAIL %s: q_out=%b expected=%b (clr_n=%b en_n=%b sel=%0d din=%b)",
                     req, q_out, expv, clr_n, en_n, sel, din);
        end
    endtask

    // Drive one cycle, check before and after the rising edge.
    task automatic step(input logic c, input logic e, input logic [2:0] s,
                        input logic d, input string pre_req, input string post_req);
        @(negedge clk);
        clr_n = c; en_n = e; sel = s; din = d;
        #1 check(exp_now(), pre_req);
        @(posedge clk);
        if (!c && e)       ref_q = 8'h00;
        else if (!c && !e) ref_q = {7'b0, d} << s;
        else if (c && !e)  ref_q[s] = d;
        #1 check(exp_now(), post_req);
    endtask

    task automatic fill(input logic [7:0] pat);
        for (int i = 0; i < 8; i++) step(1'b1, 1'b0, 3'(i), pat[i], "R1", "R1 R2 R6");
    endtask

    initial begin
        logic [7:0] pats [4];
        pats[0] = 8'hA5; pats[1] = 8'h3C; pats[2] = 8'hFF; pats[3] = 8'h01;

        // Reset through clear mode
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 3'(i), 1'b1, "R5", "R5");
        step(1'b1, 1'b1, 3'd5, 1'b1, "R8", "R8");

        // Writes then address/data sweeps with enable held high
        foreach (pats[p]) begin
            fill(pats[p]);
            for (int s = 0; s < 8; s++)
                for (int d = 0; d < 2; d++)
                    step(1'b1, 1'b1, 3'(s), 1'(d), "R3", "R3");
        end

        // Single-bit write at each address from all-zero and all-one states
        for (int s = 0; s < 8; s++) begin
            fill(8'h00);
            step(1'b1, 1'b0, 3'(s), 1'b1, "R1", "R1 R6");
            fill(8'hFF);
            step(1'b1, 1'b0, 3'(s), 1'b0, "R1", "R1 R2 R6");
        end

        // Demultiplex at every address and data value, then expose storage
        for (int s = 0; s < 8; s++) begin
            for (int d = 0; d < 2; d++) begin
                fill(8'hFF);
                step(1'b0, 1'b0, 3'(s), 1'(d), "R4", "R4 R6");
                step(1'b1, 1'b1, 3'((s + 3) % 8), ~1'(d), "R7", "R7");
            end
        end

        // Asynchronous clear from a loaded state, then expose storage
        foreach (pats[p]) begin
            fill(pats[p]);
            step(1'b0, 1'b1, 3'(p * 2), 1'b1, "R5", "R5");
            step(1'b1, 1'b1, 3'(p), 1'b1, "R8", "R8");
        end

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_errs++;
            $display("FAIL watchdog: run did not complete, got timeout expected finish");
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end

endmodule